// File: doc/BRIEF.md
# Intel Hex Record Loader

This block sits between a UART receiver and a byte-programmable flash port. Once software opens a load session, it reads an ASCII character stream one Intel Hex line at a time. A line starts with a colon. The colon is followed by hex digit pairs that encode a byte count, a 16-bit address, a record type, the data bytes and a checksum byte. The line ends with a carriage return or a line feed. The block converts the digits, keeps a running 8-bit sum, and holds the data bytes of the line in a small buffer. Nothing from a line reaches flash until the whole line has been checked.

When a data line checks out, its bytes are written one at a time through a request/done flash port. The flash reports pass or fail for each byte. Addresses from 8000h to 807Fh select the 128-byte configuration region, and lower addresses select the main array. When the security input is low, the main array is protected. After each line, one verdict character goes out on the transmit side:

- `.` means every byte was written.
- `X` means a write was refused or failed.
- `E` means the line was malformed or its checksum was wrong.
- `T` means the terminating record arrived and the session is over.

An echo toggle lets the received characters be copied back to the transmitter.

Top module: `hex_record_loader`

## Requirements
- R1: After reset no session is open, echo is off, tx_valid is 0 and fl_req is 0.
- R2: A load_start pulse opens a session only while load_enable is 1. With load_enable at 0 the command is rejected, and the lines that follow produce no verdict and no flash request.
- R3: In a session, characters before ':' (3Ah) are ignored. The line fields are, in order: count, address high byte, address low byte, type, data bytes, checksum. Each field is two hex digits, and upper- and lower-case digits are both accepted.
- R4: A type 00h line that passes its checks writes data byte i to address+i, in order. It then returns '.' (2Eh).
- R5: A line is accepted only when the 8-bit sum of all its bytes, checksum included, is 00h. Otherwise it returns 'E' (45h) and makes no flash request.
- R6: A line returns 'E' with no flash request in any of these cases: it contains a non-hex character, it ends before count+5 bytes, it carries extra digits, its count is above 16, or its type is not 00h or 01h.
- R7: A byte that the flash reports as failed ends the line with 'X' (58h). No later byte of that line is requested.
- R8: While secure_ok is 0, addresses below 8000h are never requested and end the line with 'X'. Addresses from 8000h to 807Fh are still written, and fl_cfg_sel is 1 for them. Addresses above 807Fh always end the line with 'X'.
- R9: A type 01h line returns 'T' (54h) and closes the session. After that, lines produce no verdict until a new load_start.
- R10: Each echo_toggle pulse flips echo. While echo is on, every received character appears on tx_data one cycle after it is accepted.
- R11: 'E' and 'T' appear two cycles after the terminator is sampled. A data line with no write issued answers after three cycles. fl_req stays high, with address and data stable, until fl_done.
- R12: A line ends on carriage return (0Dh) or line feed (0Ah). A terminator outside a line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| load_start | input | 1 | Request to open a load session |
| load_enable | input | 1 | Load command permitted |
| secure_ok | input | 1 | 1 unlocks the main flash array |
| echo_toggle | input | 1 | Pulse flips echo on/off |
| tx_valid | output | 1 | Transmit character strobe |
| tx_data | output | 8 | Echoed character or verdict |
| fl_req | output | 1 | Flash byte write request, held until done |
| fl_addr | output | 16 | Flash write address |
| fl_data | output | 8 | Flash write data |
| fl_cfg_sel | output | 1 | Address lies in the configuration region |
| fl_done | input | 1 | Flash write complete |
| fl_ok | input | 1 | Flash write result, valid with fl_done |

## Verification
The bench tags every expected transmit character with the cycle in which it is due. An echo is due one cycle after the character is accepted. 'E' and 'T' are due two cycles after the terminator is sampled. A data line that issues no write is due after three cycles. For lines that write, the verdict depends on the flash latency, so it is checked for order only, after the last expected write. Each flash request is compared, as it rises, against a queue of expected address/data pairs built from the requirements. After every line the bench confirms that nothing expected is missing and that nothing unexpected arrived.

// File: rtl/hexld_pkg.sv
// Shared definitions for the hex record loader: controller states,
// character codes and fixed record geometry.
package hexld_pkg;
    typedef enum logic [2:0] {
        ST_OFF,    // no session
        ST_HUNT,   // waiting for start colon
        ST_BODY,   // collecting digit pairs
        ST_WRITE,  // committing next buffered byte
        ST_WAIT,   // flash write outstanding
        ST_RESP    // verdict being handed to the transmitter
    } ld_state_e;

    localparam int          ADDR_W   = 16;     // record address width
    localparam int          HDR      = 4;      // count, addr hi, addr lo, type
    localparam logic [7:0]  CH_COLON = 8'h3A;
    localparam logic [7:0]  CH_CR    = 8'h0D;
    localparam logic [7:0]  CH_LF    = 8'h0A;
    localparam logic [7:0]  V_OK     = 8'h2E;  // '.'
    localparam logic [7:0]  V_WERR   = 8'h58;  // 'X'
    localparam logic [7:0]  V_CERR   = 8'h45;  // 'E'
    localparam logic [7:0]  V_TERM   = 8'h54;  // 'T'
endpackage

// File: rtl/hexld_digit.sv
// ASCII hex digit decoder. Assumes nothing about the character;
// flags anything outside 0-9, A-F, a-f as not a digit.
module hexld_digit (
    input  logic [7:0] ch,
    output logic [3:0] nib,
    output logic       is_hex
);
    // Map one character to its nibble value.
    always_comb begin
        nib    = 4'h0;
        is_hex = 1'b1;
        if (ch >= 8'h30 && ch <= 8'h39)      nib = 4'(ch - 8'h30);
        else if (ch >= 8'h41 && ch <= 8'h46) nib = 4'(ch - 8'h37);
        else if (ch >= 8'h61 && ch <= 8'h66) nib = 4'(ch - 8'h57);
        else                                 is_hex = 1'b0;
    end
endmodule

// File: rtl/hexld_linebuf.sv
// Holding buffer for the data bytes of one line. Written while the line
// is parsed, read while it is committed; contents need no reset because
// every read position is written earlier in the same line.
module hexld_linebuf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    // Store one decoded data byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Present the byte selected by the commit sequencer.
    always_comb rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : 8'h00;
endmodule

// File: rtl/hexld_txmux.sv
// Transmit side: owns the echo flag and merges echoed characters with
// verdicts into one registered character strobe. Assumes no receive
// character lands in the verdict cycle; if one does, the verdict wins.
module hexld_txmux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       echo_toggle,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       vrd_valid,
    input  logic [7:0] vrd_char,
    output logic       tx_valid,
    output logic [7:0] tx_data
);
    logic echo_en;

    // Flip echo on each toggle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           echo_en <= 1'b0;
        else if (echo_toggle) echo_en <= ~echo_en;
    end

    // Register the outgoing character, verdict first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else if (vrd_valid) begin
            tx_valid <= 1'b1;
            tx_data  <= vrd_char;
        end else begin
            tx_valid <= rx_valid && echo_en;
            tx_data  <= rx_data;
        end
    end

    // R10
    echo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !$past(vrd_valid) |-> $past(rx_valid) && tx_data == $past(rx_data));
endmodule

// File: rtl/hex_record_loader.sv
// Intel Hex line loader. Parses one record per line from a character
// stream, checks framing and checksum, then commits data bytes to a
// request/done flash port and returns a one-character verdict.
// Assumes characters are spaced by the UART so none arrive while a
// line is being committed, and that secure_ok is static during a line.
module hex_record_loader
    import hexld_pkg::*;
#(
    parameter int              MAX_DATA  = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE = 16'h8000,
    parameter int              CFG_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              load_start,
    input  logic              load_enable,
    input  logic              secure_ok,
    input  logic              echo_toggle,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              fl_cfg_sel,
    input  logic              fl_done,
    input  logic              fl_ok
);
    localparam int BIDX_W = $clog2(MAX_DATA + 6);
    localparam int WIDX_W = $clog2(MAX_DATA + 1);
    localparam logic [ADDR_W:0] CFG_END = (ADDR_W+1)'(CFG_BASE) + (ADDR_W+1)'(CFG_BYTES);

    ld_state_e         state;
    logic [3:0]        hi_q, nib;
    logic              half_q, err_q, term_q, is_hex, is_eol;
    logic [BIDX_W-1:0] byte_idx, dofs;
    logic [7:0]        cnt_q, type_q, sum_q, byte_now, verdict, buf_rd;
    logic [ADDR_W-1:0] addr_q, addr_cur;
    logic [WIDX_W-1:0] wr_idx;
    logic              byte_strobe, buf_we, blocked;

    hexld_digit u_digit (.ch(rx_data), .nib(nib), .is_hex(is_hex));

    // Per-character decode helpers.
    always_comb begin
        is_eol      = (rx_data == CH_CR) || (rx_data == CH_LF);
        byte_now    = {hi_q, nib};
        byte_strobe = rx_valid && (state == ST_BODY) && is_hex && half_q;
        dofs        = byte_idx - BIDX_W'(HDR);
        buf_we      = byte_strobe && int'(byte_idx) >= HDR &&
                      int'(dofs) < int'(cnt_q) && int'(dofs) < MAX_DATA;
        addr_cur    = addr_q + ADDR_W'(wr_idx);
        blocked     = ({1'b0, addr_cur} >= CFG_END) || (!secure_ok && addr_cur < CFG_BASE);
        fl_cfg_sel  = (fl_addr >= CFG_BASE);
    end

    hexld_linebuf #(.DEPTH(MAX_DATA), .IDX_W(WIDX_W)) u_buf (
        .clk(clk), .wr_en(buf_we), .wr_idx(dofs[WIDX_W-1:0]), .wr_data(byte_now),
        .rd_idx(wr_idx), .rd_data(buf_rd)
    );

    hexld_txmux u_tx (
        .clk(clk), .rst_n(rst_n), .echo_toggle(echo_toggle),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .vrd_valid(state == ST_RESP), .vrd_char(verdict),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    // Session, parse and commit sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;   hi_q <= '0;    half_q <= 1'b0; err_q <= 1'b0;
            term_q <= 1'b0;    byte_idx <= '0; cnt_q <= '0;   type_q <= '0;
            sum_q <= '0;       addr_q <= '0;  wr_idx <= '0;   verdict <= V_OK;
            fl_req <= 1'b0;    fl_addr <= '0; fl_data <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    term_q <= 1'b0;
                    if (load_start && load_enable) state <= ST_HUNT;
                end
                ST_HUNT: if (rx_valid && rx_data == CH_COLON) begin
                    state <= ST_BODY; half_q <= 1'b0; byte_idx <= '0; sum_q <= '0;
                    err_q <= 1'b0;    cnt_q <= '0;    type_q <= '0;   addr_q <= '0;
                end
                ST_BODY: if (rx_valid) begin
                    if (is_eol) begin
                        if (err_q || half_q || sum_q != 8'h00 ||
                            int'(byte_idx) != int'(cnt_q) + HDR + 1) begin
                            verdict <= V_CERR; state <= ST_RESP;
                        end else if (type_q == 8'h01) begin
                            verdict <= V_TERM; term_q <= 1'b1; state <= ST_RESP;
                        end else if (type_q == 8'h00) begin
                            wr_idx <= '0; state <= ST_WRITE;
                        end else begin
                            verdict <= V_CERR; state <= ST_RESP;
                        end
                    end else if (!is_hex) begin
                        err_q <= 1'b1;
                    end else if (!half_q) begin
                        hi_q <= nib; half_q <= 1'b1;
                    end else begin
                        half_q <= 1'b0;
                        sum_q  <= sum_q + byte_now;
                        if (byte_idx != {BIDX_W{1'b1}}) byte_idx <= byte_idx + 1'b1;
                        if (int'(byte_idx) == 0) begin
                            cnt_q <= byte_now;
                            if (int'(byte_now) > MAX_DATA) err_q <= 1'b1;
                        end else if (int'(byte_idx) == 1) addr_q[15:8] <= byte_now;
                        else if (int'(byte_idx) == 2)     addr_q[7:0]  <= byte_now;
                        else if (int'(byte_idx) == 3)     type_q       <= byte_now;
                        else if (int'(dofs) > int'(cnt_q)) err_q       <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (int'(wr_idx) == int'(cnt_q)) begin
                        verdict <= V_OK; state <= ST_RESP;
                    end else if (blocked) begin
                        verdict <= V_WERR; state <= ST_RESP;
                    end else begin
                        fl_req <= 1'b1; fl_addr <= addr_cur; fl_data <= buf_rd;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (fl_done) begin
                    fl_req <= 1'b0;
                    if (fl_ok) begin
                        wr_idx <= wr_idx + 1'b1; state <= ST_WRITE;
                    end else begin
                        verdict <= V_WERR; state <= ST_RESP;
                    end
                end
                ST_RESP: state <= term_q ? ST_OFF : ST_HUNT;
                default: state <= ST_OFF;
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_done |=> fl_req && $stable(fl_addr) && $stable(fl_data));
    // R8
    secure_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !secure_ok |-> fl_cfg_sel);
    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> ({1'b0, fl_addr} < CFG_END));
    // R5
    cksum_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (sum_q == 8'h00) && !err_q);
    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !fl_req);
endmodule

// File: tb/test_hex_record_loader.sv
module test_hex_record_loader;
    localparam int CLK_PERIOD = 10;
    localparam int FL_LAT     = 3;

    logic        clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        load_start = 1'b0, load_enable = 1'b0, secure_ok = 1'b1, echo_toggle = 1'b0;
    logic        fl_done = 1'b0, fl_ok = 1'b0;
    logic        tx_valid, fl_req, fl_cfg_sel;
    logic [7:0]  tx_data, fl_data;
    logic [15:0] fl_addr;

    hex_record_loader i_hex_record_loader (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .load_start(load_start), .load_enable(load_enable), .secure_ok(secure_ok),
        .echo_toggle(echo_toggle), .tx_valid(tx_valid), .tx_data(tx_data),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_data(fl_data), .fl_cfg_sel(fl_cfg_sel),
        .fl_done(fl_done), .fl_ok(fl_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int exp_ch[$], exp_due[$], exp_wa[$], exp_wd[$];
    bit echo_on = 1'b0, sess = 1'b0, fl_pend = 1'b0;
    int fail_addr = -1, fl_cnt = 0;

    task automatic fail(string req, string what, int act, int expv);
        n_bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Transmit monitor: every character against the expected queue and its due cycle.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            n_chk++;
            if (exp_ch.size() == 0) fail("R2/R10", "unexpected tx", int'(tx_data), -1);
            else begin
                int c, d;
                c = exp_ch.pop_front();
                d = exp_due.pop_front();
                if (int'(tx_data) != c) fail("R4-verdict/R10", "tx char", int'(tx_data), c);
                else if (d >= 0 && cyc != d) fail("R11", "tx cycle", cyc, d);
            end
        end
    end

    // Flash model: fixed latency, fails one chosen address, checks each request.
    always @(negedge clk) begin
        if (fl_done) fl_done = 1'b0;
        else if (rst_n && fl_req && !fl_pend) begin
            fl_pend = 1'b1;
            fl_cnt  = FL_LAT;
            n_chk++;
            if (exp_wa.size() == 0) fail("R5/R8", "unexpected write", int'(fl_addr), -1);
            else begin
                int a, v;
                a = exp_wa.pop_front();
                v = exp_wd.pop_front();
                if (int'(fl_addr) != a) fail("R4", "write addr", int'(fl_addr), a);
                else if (int'(fl_data) != v) fail("R4", "write data", int'(fl_data), v);
                else if (fl_cfg_sel != (a >= 32768)) fail("R8", "cfg select", int'(fl_cfg_sel), int'(a >= 32768));
            end
        end else if (fl_pend) begin
            fl_cnt--;
            if (fl_cnt == 0) begin
                fl_done = 1'b1;
                fl_ok   = (int'(fl_addr) != fail_addr);
                fl_pend = 1'b0;
            end
        end
    end

    function automatic logic [7:0] hx(int v, bit lc);
        v = v & 15;
        return (v < 10) ? 8'(8'h30 + v) : 8'((lc ? 8'h61 : 8'h41) + v - 10);
    endfunction

    task automatic send_char(logic [7:0] ch, output int c0);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = ch;
        c0 = cyc;
        if (echo_on) begin exp_ch.push_back(int'(ch)); exp_due.push_back(cyc + 1); end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_start(bit en);
        load_enable = en;
        @(negedge clk) load_start = 1'b1;
        @(negedge clk) load_start = 1'b0;
        if (en) sess = 1'b1;
    endtask

    task automatic flip_echo();
        @(negedge clk) echo_toggle = 1'b1;
        @(negedge clk) echo_toggle = 1'b0;
        echo_on = !echo_on;
    endtask

    // flavor: 0 plain, 1 non-hex inserted, 2 checksum pair dropped, 3 extra pair, 4 lower case
    task automatic run_line(string tag, int n, int addr, int typ, int sumdelta,
                            int flavor, logic [7:0] term, bit prefix);
        int b[$];
        int s = 0, v = -1, off = 2, pushed = 0, c0 = 0, w = 0;
        b.push_back(n & 255); b.push_back((addr >> 8) & 255);
        b.push_back(addr & 255); b.push_back(typ & 255);
        for (int i = 0; i < n; i++) b.push_back((addr * 3 + i * 29 + 5) & 255);
        foreach (b[k]) s += b[k];
        b.push_back((256 - (s & 255) + sumdelta) & 255);
        if (sess) begin
            if ((flavor >= 1 && flavor <= 3) || sumdelta != 0 || n > 16 || typ > 1) v = 8'h45;
            else if (typ == 1) v = 8'h54;
            else begin
                off = 3;
                for (int i = 0; i < n; i++) begin
                    int a = (addr + i) & 16'hFFFF;
                    if (a >= 16'h8080 || (!secure_ok && a < 16'h8000)) begin v = 8'h58; break; end
                    exp_wa.push_back(a); exp_wd.push_back(b[4 + i]); pushed++;
                    if (a == fail_addr) begin v = 8'h58; break; end
                end
                if (v < 0) v = 8'h2E;
            end
        end
        if (prefix) begin send_char(8'h71, c0); send_char(8'h0D, c0); end
        send_char(8'h3A, c0);
        foreach (b[k]) begin
            if (!(flavor == 2 && k == b.size() - 1)) begin
                send_char(hx(b[k] >> 4, flavor == 4), c0);
                send_char(hx(b[k], flavor == 4), c0);
            end
            if (flavor == 1 && k == 2) send_char(8'h47, c0);
        end
        if (flavor == 3) begin send_char(8'h30, c0); send_char(8'h30, c0); end
        send_char(term, c0);
        if (v >= 0) begin
            exp_ch.push_back(v);
            exp_due.push_back(pushed > 0 ? -1 : c0 + off);
            if (v == 8'h54) sess = 1'b0;
        end
        while ((exp_ch.size() != 0 || exp_wa.size() != 0) && w < 400) begin
            @(negedge clk); w++;
        end
        repeat (4) @(negedge clk);
        n_chk++;
        if (exp_ch.size() != 0 || exp_wa.size() != 0)
            fail(tag, "missing output", exp_ch.size() + exp_wa.size(), 0);
        exp_ch.delete(); exp_due.delete(); exp_wa.delete(); exp_wd.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fail("R11", "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (tx_valid !== 1'b0 || fl_req !== 1'b0) fail("R1", "reset outputs", {tx_valid, fl_req}, 0);
        // R1 and R2: no session yet and load disabled, so the line must be silent
        run_line("R1", 2, 16'h0040, 0, 0, 0, 8'h0D, 0);
        pulse_start(1'b0);
        run_line("R2", 2, 16'h0040, 0, 0, 0, 8'h0D, 0);
        pulse_start(1'b1);
        run_line("R3", 4, 16'h0100, 0, 0, 0, 8'h0D, 1);   // R3 junk before colon
        run_line("R3", 3, 16'h0110, 0, 0, 4, 8'h0D, 0);   // R3 lower-case digits
        flip_echo();
        run_line("R10", 3, 16'h0120, 0, 0, 0, 8'h0D, 0);  // R10 echo on
        flip_echo();
        run_line("R10", 1, 16'h0130, 0, 0, 0, 8'h0D, 0);  // R10 echo off again
        run_line("R5", 4, 16'h0140, 0, 1, 0, 8'h0D, 0);   // R5 bad checksum
        run_line("R6", 2, 16'h0150, 0, 0, 1, 8'h0D, 0);   // R6 non-hex
        run_line("R6", 2, 16'h0150, 0, 0, 2, 8'h0D, 0);   // R6 short line
        run_line("R6", 2, 16'h0150, 0, 0, 3, 8'h0D, 0);   // R6 extra digits
        run_line("R6", 2, 16'h0150, 2, 0, 0, 8'h0D, 0);   // R6 unknown type
        run_line("R6", 17, 16'h0160, 0, 0, 0, 8'h0D, 0);  // R6 count above 16
        run_line("R4", 16, 16'h0180, 0, 0, 0, 8'h0D, 0);  // R4 full buffer
        run_line("R11", 0, 16'h0000, 0, 0, 0, 8'h0D, 0);  // R11 empty data line
        fail_addr = 16'h0202;
        run_line("R7", 4, 16'h0200, 0, 0, 0, 8'h0D, 0);   // R7 stop at failed byte
        fail_addr = -1;
        secure_ok = 1'b0;
        run_line("R8", 2, 16'h0010, 0, 0, 0, 8'h0D, 0);   // R8 main array locked
        run_line("R8", 16, 16'h8000, 0, 0, 0, 8'h0D, 0);  // R8 config region open
        run_line("R8", 4, 16'h807E, 0, 0, 0, 8'h0D, 0);   // R8 past region end
        secure_ok = 1'b1;
        run_line("R12", 2, 16'h0300, 0, 0, 0, 8'h0A, 0);  // R12 line feed end
        run_line("R9", 0, 16'h0000, 1, 0, 0, 8'h0D, 0);   // R9 terminating record
        run_line("R9", 2, 16'h0310, 0, 0, 0, 8'h0D, 0);   // R9 session closed
        pulse_start(1'b1);
        run_line("R2", 2, 16'h0320, 0, 0, 0, 8'h0D, 0);
        summary();
        $finish;
    end
endmodule